// File: doc/BRIEF.md
# Boot-Time Flash Restore Sequencer

This block runs once after every reset, before the normal command shell takes over. It first asks the SD card front end to initialise the card, then fetches a small control record from a fixed SD block address. The record says whether a restore is armed. When it is armed and self-consistent, the block copies a staged image from SD into the boot slot of the flash. It erases each flash sector just before the first page in it is programmed. It then reads every block back from both SD and flash and compares them byte for byte.

The SD and flash front ends own all card and flash signalling. This block only issues commands and moves bytes between them. Every command and data path is valid/ready. A request output holds its valid and its payload until ready is seen. A byte moves only in a cycle where both valid and ready are high. While copying, back-pressure from the flash write path stalls the SD read stream directly: there is no page buffer. While verifying, a byte is consumed from both sources only when both have one ready.

An operator is never locked out. Any UART receive strobe ends the sequence in the very next clock edge, whatever state the block is in, and hands control to the shell. The control record is 512 bytes on a real card, but only its first 16 bytes carry meaning. It holds four little-endian 32-bit words:

- an arming word that must equal `MAGIC`;
- the first source LBA;
- the image length in bytes;
- a checksum equal to the 32-bit sum of the first three words.

Top module: `boot_restore_seq`

## Requirements
- R1: From reset, the block asks for SD initialisation (`sd_init_req` high), shows status 0 (idle) with `shell_go` and `done_pulse` low, and issues no SD read and no flash command.
- R2: If SD initialisation reports failure (`sd_init_done` with `sd_init_ok` low), the block finishes with status 1 (skipped) and touches no flash.
- R3: After a good initialisation, the block reads exactly one block from LBA `CTRL_LBA`. If word 0 (bytes 0..3, little-endian) differs from `MAGIC`, it finishes with status 1 (skipped) and issues no flash command.
- R4: An armed record finishes with status 3 (checksum fail) and no flash command if any of these holds: word 3 (bytes 12..15) differs from word0+word1+word2 modulo 2^32; the length (word 2, bytes 8..11) is 0; or the length exceeds `SLOT_BYTES`.
- R5: Flash commands use op encoding erase=0, program=1, read=2. Erase commands go to consecutive sector addresses `SLOT_BASE + k*SECTOR_BYTES`, starting at k=0. Each erase is issued before any program in that sector. The number of erases is ceil(copied bytes / `SECTOR_BYTES`).
- R6: Program commands each carry `PAGE_BYTES` data bytes and go to consecutive page addresses from `SLOT_BASE`. Once a command's bytes are sent, and once an erase is accepted, the block skips one cycle and then waits for `fl_ready` before it issues its next flash command.
- R7: Source block n is read from SD LBA `src + n`, where `src` is word 1 (bytes 4..7). No LBA beyond the last source block is requested.
- R8: After programming, each copied block is read again from SD and from flash (read command at the same slot address, `BLOCK_BYTES` bytes long) and compared. If every byte matches, the block finishes with status 5 (done).
- R9: The first byte that differs during verify ends the sequence with status 4 (verify fail).
- R10: A high `uart_rx_seen` in any unfinished state ends the sequence at the next clock edge with status 2 (aborted). No further SD read or flash command follows.
- R11: Every finish raises `done_pulse` for exactly one cycle. After that, `status` holds its value and `shell_go` stays high until reset.
- R12: At most one of `sd_init_req`, `sd_rd_valid` and `fl_cmd_valid` is high at a time. A request waiting for ready keeps its payload stable. Data bytes move only on valid-and-ready cycles, so the flash ends up holding the source bytes exactly.
- R13: The copied length is the image length rounded up to whole SD blocks. Bytes of the last block beyond the image length are still programmed and verified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restarts the sequence |
| uart_rx_seen | input | 1 | Strobe: a UART byte arrived |
| sd_init_req | output | 1 | Held high while waiting for card initialisation |
| sd_init_done | input | 1 | Initialisation finished |
| sd_init_ok | input | 1 | Initialisation succeeded (valid with done) |
| sd_rd_valid | output | 1 | Block read request valid |
| sd_rd_ready | input | 1 | Block read request accepted |
| sd_rd_lba | output | 32 | LBA of the requested block |
| sd_dat_valid | input | 1 | SD read byte valid |
| sd_dat_ready | output | 1 | SD read byte accepted |
| sd_dat | input | 8 | SD read byte |
| fl_cmd_valid | output | 1 | Flash command valid |
| fl_cmd_ready | input | 1 | Flash command accepted |
| fl_cmd_op | output | 2 | 0 erase sector, 1 program page, 2 read block |
| fl_cmd_addr | output | ADDR_W | Flash byte address of the command |
| fl_ready | input | 1 | Flash front end idle (no erase or program in progress) |
| fl_wdat_valid | output | 1 | Program byte valid |
| fl_wdat_ready | input | 1 | Program byte accepted |
| fl_wdat | output | 8 | Program byte |
| fl_rdat_valid | input | 1 | Flash read byte valid |
| fl_rdat_ready | output | 1 | Flash read byte accepted |
| fl_rdat | input | 8 | Flash read byte |
| done_pulse | output | 1 | One-cycle strobe when the sequence finishes |
| status | output | 3 | 0 idle, 1 skipped, 2 aborted, 3 checksum fail, 4 verify fail, 5 done |
| shell_go | output | 1 | High once the sequence has finished |

## Verification
The bench builds the block with 8-byte pages, 16-byte SD blocks, 32-byte sectors and a 128-byte slot. With these sizes a whole slot is 8 blocks, 16 pages and 4 sectors. Every path can then be reached within a few thousand cycles: a sector boundary in the middle of the copy, a partial final sector, a length of exactly one slot, and a length one byte over it. Because the record fills a whole 16-byte block, the control read path sees the same block length as the data blocks.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE        = 3'd0,
    ST_SKIPPED     = 3'd1,
    ST_ABORTED     = 3'd2,
    ST_CSUM_FAIL   = 3'd3,
    ST_VERIFY_FAIL = 3'd4,
    ST_DONE        = 3'd5
  } rsq_status_e;

  typedef enum logic [1:0] {
    OP_ERASE = 2'd0,
    OP_PROG  = 2'd1,
    OP_READ  = 2'd2
  } rsq_op_e;

  typedef enum logic [1:0] {
    RT_NONE,
    RT_SINK,
    RT_COPY,
    RT_CMP
  } rsq_route_e;

  typedef enum logic [4:0] {
    S_INIT,
    S_CB_REQ,
    S_CB_DATA,
    S_CB_EVAL,
    S_ER_CMD,
    S_ER_GAP,
    S_ER_WAIT,
    S_RD_REQ,
    S_PG_CMD,
    S_PG_DATA,
    S_PG_GAP,
    S_PG_WAIT,
    S_VF_SD,
    S_VF_FL,
    S_VF_DATA,
    S_FIN
  } rsq_state_e;

endpackage

// File: rtl/rsq_ctrl_parse.sv
module rsq_ctrl_parse #(
  parameter int          SLOT_BYTES = 1048576,
  parameter logic [31:0] MAGIC      = 32'h5A17_C0DE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [7:0]  wr_byte,
  output logic        armed,
  output logic        valid,
  output logic [31:0] src_lba,
  output logic [31:0] img_len
);
  localparam int NWORDS = 4;

  logic [31:0] word_q [NWORDS];
  logic [31:0] sum;

  // One little-endian word register per field, filled byte by byte.
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '0;
      end else if (wr_en && (int'(wr_idx[3:2]) == w)) begin
        word_q[w][wr_idx[1:0]*8 +: 8] <= wr_byte;
      end
    end
  end

  assign sum     = word_q[0] + word_q[1] + word_q[2];
  assign armed   = (word_q[0] == MAGIC);
  assign src_lba = word_q[1];
  assign img_len = word_q[2];
  assign valid   = armed && (sum == word_q[3]) && (img_len != '0)
                   && (img_len <= 32'(SLOT_BYTES));

endmodule

// File: rtl/rsq_stream_route.sv
module rsq_stream_route
  import rsq_pkg::*;
(
  input  rsq_route_e route,
  input  logic       sd_dat_valid,
  output logic       sd_dat_ready,
  input  logic [7:0] sd_dat,
  output logic       fl_wdat_valid,
  input  logic       fl_wdat_ready,
  output logic [7:0] fl_wdat,
  input  logic       fl_rdat_valid,
  output logic       fl_rdat_ready,
  input  logic [7:0] fl_rdat,
  output logic       xfer,
  output logic       mismatch
);
  logic both;

  assign both    = sd_dat_valid && fl_rdat_valid;
  assign fl_wdat = sd_dat;

  always_comb begin
    sd_dat_ready  = 1'b0;
    fl_wdat_valid = 1'b0;
    fl_rdat_ready = 1'b0;
    xfer          = 1'b0;
    mismatch      = 1'b0;
    unique case (route)
      RT_SINK: begin
        sd_dat_ready = 1'b1;
        xfer         = sd_dat_valid;
      end
      RT_COPY: begin
        sd_dat_ready  = fl_wdat_ready;
        fl_wdat_valid = sd_dat_valid;
        xfer          = sd_dat_valid && fl_wdat_ready;
      end
      RT_CMP: begin
        sd_dat_ready  = both;
        fl_rdat_ready = both;
        xfer          = both;
        mismatch      = both && (sd_dat != fl_rdat);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/boot_restore_seq.sv
module boot_restore_seq
  import rsq_pkg::*;
#(
  parameter int                PAGE_BYTES   = 256,
  parameter int                BLOCK_BYTES  = 512,
  parameter int                SECTOR_BYTES = 65536,
  parameter int                SLOT_BYTES   = 1048576,
  parameter int                ADDR_W       = 24,
  parameter logic [ADDR_W-1:0] SLOT_BASE    = '0,
  parameter logic [31:0]       CTRL_LBA     = 32'd1,
  parameter logic [31:0]       MAGIC        = 32'h5A17_C0DE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uart_rx_seen,
  output logic              sd_init_req,
  input  logic              sd_init_done,
  input  logic              sd_init_ok,
  output logic              sd_rd_valid,
  input  logic              sd_rd_ready,
  output logic [31:0]       sd_rd_lba,
  input  logic              sd_dat_valid,
  output logic              sd_dat_ready,
  input  logic [7:0]        sd_dat,
  output logic              fl_cmd_valid,
  input  logic              fl_cmd_ready,
  output logic [1:0]        fl_cmd_op,
  output logic [ADDR_W-1:0] fl_cmd_addr,
  input  logic              fl_ready,
  output logic              fl_wdat_valid,
  input  logic              fl_wdat_ready,
  output logic [7:0]        fl_wdat,
  input  logic              fl_rdat_valid,
  output logic              fl_rdat_ready,
  input  logic [7:0]        fl_rdat,
  output logic              done_pulse,
  output logic [2:0]        status,
  output logic              shell_go
);
  localparam int BLK_SH      = $clog2(BLOCK_BYTES);
  localparam int BYTE_W      = BLK_SH;
  localparam int MAX_BLK     = SLOT_BYTES / BLOCK_BYTES;
  localparam int BLK_W       = $clog2(MAX_BLK + 1);
  localparam int BLK_PER_SEC = SECTOR_BYTES / BLOCK_BYTES;

  rsq_state_e        state_q;
  rsq_status_e       status_q;
  logic              done_q;
  logic [BLK_W-1:0]  blk_q, nblk_q, blk_nxt, nblk_c;
  logic [BYTE_W-1:0] cnt_q;
  logic [31:0]       len_rnd;
  logic [ADDR_W-1:0] blk_base;
  logic              cb_armed, cb_valid;
  logic [31:0]       src_lba, img_len;
  logic              xfer, mismatch;
  logic              last_byte, page_last, sector_edge;
  rsq_route_e        route;

  rsq_ctrl_parse #(.SLOT_BYTES(SLOT_BYTES), .MAGIC(MAGIC)) u_parse (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   ((state_q == S_CB_DATA) && xfer && (int'(cnt_q) < 16)),
    .wr_idx  (cnt_q[3:0]),
    .wr_byte (sd_dat),
    .armed   (cb_armed),
    .valid   (cb_valid),
    .src_lba (src_lba),
    .img_len (img_len)
  );

  always_comb begin
    unique case (state_q)
      S_CB_DATA: route = RT_SINK;
      S_PG_DATA: route = RT_COPY;
      S_VF_DATA: route = RT_CMP;
      default:   route = RT_NONE;
    endcase
  end

  rsq_stream_route u_route (
    .route         (route),
    .sd_dat_valid  (sd_dat_valid),
    .sd_dat_ready  (sd_dat_ready),
    .sd_dat        (sd_dat),
    .fl_wdat_valid (fl_wdat_valid),
    .fl_wdat_ready (fl_wdat_ready),
    .fl_wdat       (fl_wdat),
    .fl_rdat_valid (fl_rdat_valid),
    .fl_rdat_ready (fl_rdat_ready),
    .fl_rdat       (fl_rdat),
    .xfer          (xfer),
    .mismatch      (mismatch)
  );

  // Geometry of the walk: blocks, pages inside a block, sector edges.
  assign len_rnd     = img_len + 32'(BLOCK_BYTES - 1);
  assign nblk_c      = BLK_W'(len_rnd >> BLK_SH);
  assign blk_nxt     = blk_q + 1'b1;
  assign blk_base    = SLOT_BASE + (ADDR_W'(blk_q) << BLK_SH);
  assign last_byte   = (cnt_q == BYTE_W'(BLOCK_BYTES - 1));
  assign page_last   = ((int'(cnt_q) % PAGE_BYTES) == PAGE_BYTES - 1);
  assign sector_edge = ((int'(blk_nxt) % BLK_PER_SEC) == 0);

  // Request outputs decoded from the state: one channel at a time.
  assign sd_init_req = (state_q == S_INIT);
  assign sd_rd_valid = (state_q == S_CB_REQ) || (state_q == S_RD_REQ)
                       || (state_q == S_VF_SD);
  assign sd_rd_lba   = (state_q == S_CB_REQ) ? CTRL_LBA
                                             : src_lba + 32'(blk_q);

  always_comb begin
    fl_cmd_valid = 1'b0;
    fl_cmd_op    = OP_ERASE;
    fl_cmd_addr  = blk_base;
    unique case (state_q)
      S_ER_CMD: fl_cmd_valid = 1'b1;
      S_PG_CMD: begin
        fl_cmd_valid = 1'b1;
        fl_cmd_op    = OP_PROG;
        fl_cmd_addr  = blk_base + ADDR_W'(cnt_q);
      end
      S_VF_FL: begin
        fl_cmd_valid = 1'b1;
        fl_cmd_op    = OP_READ;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_INIT;
      status_q <= ST_IDLE;
      done_q   <= 1'b0;
      blk_q    <= '0;
      nblk_q   <= '0;
      cnt_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if ((state_q != S_FIN) && uart_rx_seen) begin
        state_q  <= S_FIN;
        status_q <= ST_ABORTED;
        done_q   <= 1'b1;
      end else begin
        unique case (state_q)
          S_INIT: if (sd_init_done) begin
            if (sd_init_ok) begin
              state_q <= S_CB_REQ;
            end else begin
              state_q  <= S_FIN;
              status_q <= ST_SKIPPED;
              done_q   <= 1'b1;
            end
          end
          S_CB_REQ: if (sd_rd_ready) begin
            cnt_q   <= '0;
            state_q <= S_CB_DATA;
          end
          S_CB_DATA: if (xfer) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_byte) state_q <= S_CB_EVAL;
          end
          S_CB_EVAL: begin
            if (!cb_armed) begin
              state_q  <= S_FIN;
              status_q <= ST_SKIPPED;
              done_q   <= 1'b1;
            end else if (!cb_valid) begin
              state_q  <= S_FIN;
              status_q <= ST_CSUM_FAIL;
              done_q   <= 1'b1;
            end else begin
              nblk_q  <= nblk_c;
              blk_q   <= '0;
              state_q <= S_ER_CMD;
            end
          end
          S_ER_CMD:  if (fl_cmd_ready) state_q <= S_ER_GAP;
          S_ER_GAP:  state_q <= S_ER_WAIT;
          S_ER_WAIT: if (fl_ready) state_q <= S_RD_REQ;
          S_RD_REQ: if (sd_rd_ready) begin
            cnt_q   <= '0;
            state_q <= S_PG_CMD;
          end
          S_PG_CMD: if (fl_cmd_ready) state_q <= S_PG_DATA;
          S_PG_DATA: if (xfer) begin
            cnt_q <= cnt_q + 1'b1;
            if (page_last) state_q <= S_PG_GAP;
          end
          S_PG_GAP: state_q <= S_PG_WAIT;
          S_PG_WAIT: if (fl_ready) begin
            if (cnt_q != '0) begin
              state_q <= S_PG_CMD;
            end else if (blk_nxt == nblk_q) begin
              blk_q   <= '0;
              state_q <= S_VF_SD;
            end else begin
              blk_q   <= blk_nxt;
              state_q <= sector_edge ? S_ER_CMD : S_RD_REQ;
            end
          end
          S_VF_SD: if (sd_rd_ready) begin
            cnt_q   <= '0;
            state_q <= S_VF_FL;
          end
          S_VF_FL: if (fl_cmd_ready) state_q <= S_VF_DATA;
          S_VF_DATA: if (xfer) begin
            if (mismatch) begin
              state_q  <= S_FIN;
              status_q <= ST_VERIFY_FAIL;
              done_q   <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              if (last_byte) begin
                if (blk_nxt == nblk_q) begin
                  state_q  <= S_FIN;
                  status_q <= ST_DONE;
                  done_q   <= 1'b1;
                end else begin
                  blk_q   <= blk_nxt;
                  state_q <= S_VF_SD;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign done_pulse = done_q;
  assign status     = status_q;
  assign shell_go   = (state_q == S_FIN);

endmodule

// File: rtl/rsq_check.sv
module rsq_check #(
  parameter int                SECTOR_BYTES = 65536,
  parameter int                SLOT_BYTES   = 1048576,
  parameter int                ADDR_W       = 24,
  parameter logic [ADDR_W-1:0] SLOT_BASE    = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              uart_rx_seen,
  input logic              sd_init_req,
  input logic              sd_rd_valid,
  input logic              sd_rd_ready,
  input logic [31:0]       sd_rd_lba,
  input logic              fl_cmd_valid,
  input logic              fl_cmd_ready,
  input logic [1:0]        fl_cmd_op,
  input logic [ADDR_W-1:0] fl_cmd_addr,
  input logic              done_pulse,
  input logic [2:0]        status,
  input logic              shell_go
);
  int erased_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) erased_q <= 0;
    else if (fl_cmd_valid && fl_cmd_ready && (fl_cmd_op == 2'd0))
      erased_q <= erased_q + 1;
  end

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R11
  final_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 3'd0) |=> ($stable(status) && shell_go));

  // R11
  done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (status != 3'd0));

  // R12
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sd_init_req, sd_rd_valid, fl_cmd_valid}));

  // R12
  sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_rd_valid && !sd_rd_ready && !uart_rx_seen)
      |=> (sd_rd_valid && $stable(sd_rd_lba)));

  // R12
  fl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid && !fl_cmd_ready && !uart_rx_seen)
      |=> (fl_cmd_valid && $stable(fl_cmd_op) && $stable(fl_cmd_addr)));

  // R5
  erase_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid && (fl_cmd_op == 2'd1))
      |-> (int'((fl_cmd_addr - SLOT_BASE) / ADDR_W'(SECTOR_BYTES)) < erased_q));

  // R5
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd_valid |-> ((fl_cmd_addr - SLOT_BASE) < ADDR_W'(SLOT_BYTES)));

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_rx_seen && (status == 3'd0)) |=> (status == 3'd2));

  // R10
  quiet_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shell_go |-> !(sd_rd_valid || fl_cmd_valid || sd_init_req));

endmodule

bind boot_restore_seq rsq_check #(
  .SECTOR_BYTES (SECTOR_BYTES),
  .SLOT_BYTES   (SLOT_BYTES),
  .ADDR_W       (ADDR_W),
  .SLOT_BASE    (SLOT_BASE)
) u_rsq_check (
  .clk          (clk),
  .rst_n        (rst_n),
  .uart_rx_seen (uart_rx_seen),
  .sd_init_req  (sd_init_req),
  .sd_rd_valid  (sd_rd_valid),
  .sd_rd_ready  (sd_rd_ready),
  .sd_rd_lba    (sd_rd_lba),
  .fl_cmd_valid (fl_cmd_valid),
  .fl_cmd_ready (fl_cmd_ready),
  .fl_cmd_op    (fl_cmd_op),
  .fl_cmd_addr  (fl_cmd_addr),
  .done_pulse   (done_pulse),
  .status       (status),
  .shell_go     (shell_go)
);

// File: tb/boot_restore_seq_test.sv
`timescale 1ns/1ps
module boot_restore_seq_test;
  localparam int PG = 8, BLK = 16, SEC = 32, SLOT = 128, AW = 24;
  localparam logic [31:0] MAGIC = 32'h5A17_C0DE;
  localparam int SRC = 100;

  logic clk = 1'b0, rst_n = 1'b0, uart_rx_seen = 1'b0;
  logic sd_init_req, sd_init_done, sd_init_ok;
  logic sd_rd_valid, sd_rd_ready;
  logic [31:0] sd_rd_lba;
  logic sd_dat_valid, sd_dat_ready;
  logic [7:0] sd_dat;
  logic fl_cmd_valid, fl_cmd_ready;
  logic [1:0] fl_cmd_op;
  logic [AW-1:0] fl_cmd_addr;
  logic fl_ready, fl_wdat_valid, fl_wdat_ready, fl_rdat_valid, fl_rdat_ready;
  logic [7:0] fl_wdat, fl_rdat;
  logic done_pulse, shell_go;
  logic [2:0] status;

  always #2.5 clk = ~clk;

  boot_restore_seq #(.PAGE_BYTES(PG), .BLOCK_BYTES(BLK), .SECTOR_BYTES(SEC),
                     .SLOT_BYTES(SLOT), .ADDR_W(AW), .CTRL_LBA(32'd1),
                     .MAGIC(MAGIC)) uut (
    .clk(clk), .rst_n(rst_n), .uart_rx_seen(uart_rx_seen),
    .sd_init_req(sd_init_req), .sd_init_done(sd_init_done), .sd_init_ok(sd_init_ok),
    .sd_rd_valid(sd_rd_valid), .sd_rd_ready(sd_rd_ready), .sd_rd_lba(sd_rd_lba),
    .sd_dat_valid(sd_dat_valid), .sd_dat_ready(sd_dat_ready), .sd_dat(sd_dat),
    .fl_cmd_valid(fl_cmd_valid), .fl_cmd_ready(fl_cmd_ready), .fl_cmd_op(fl_cmd_op),
    .fl_cmd_addr(fl_cmd_addr), .fl_ready(fl_ready),
    .fl_wdat_valid(fl_wdat_valid), .fl_wdat_ready(fl_wdat_ready), .fl_wdat(fl_wdat),
    .fl_rdat_valid(fl_rdat_valid), .fl_rdat_ready(fl_rdat_ready), .fl_rdat(fl_rdat),
    .done_pulse(done_pulse), .status(status), .shell_go(shell_go));

  // scenario configuration
  logic cfg_init_ok, cfg_armed, cfg_bad;
  logic [31:0] cfg_len;
  int exp_nblk, vf_addr;
  logic [7:0] vf_xor;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] src_byte(input int i);
    return 8'(i * 7 + 3);
  endfunction

  function automatic logic [31:0] cb_word(input int w);
    logic [31:0] w0;
    w0 = cfg_armed ? MAGIC : 32'h0000_1234;
    case (w)
      0: return w0;
      1: return 32'(SRC);
      2: return cfg_len;
      default: return w0 + 32'(SRC) + cfg_len + (cfg_bad ? 32'd1 : 32'd0);
    endcase
  endfunction

  function automatic logic [7:0] sd_byte(input logic [31:0] lba, input int idx);
    logic [31:0] w;
    if (lba == 32'd1) begin
      w = cb_word(idx / 4);
      return w[(idx % 4) * 8 +: 8];
    end
    if (lba >= 32'(SRC)) return src_byte((int'(lba) - SRC) * BLK + idx);
    return 8'h00;
  endfunction

  // ---------------- SD front-end model ----------------
  int tick, init_dly, sd_cnt, data_reads, cb_reads, bad_lba;
  logic sd_str;
  logic [31:0] sd_lba_q;

  assign sd_init_ok   = cfg_init_ok;
  assign sd_rd_ready  = !sd_str && tick[0];
  assign sd_dat_valid = sd_str && ((tick % 3) != 0);
  assign sd_dat       = sd_byte(sd_lba_q, sd_cnt);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= 0; init_dly <= 0; sd_init_done <= 1'b0; sd_str <= 1'b0;
      sd_cnt <= 0; sd_lba_q <= '0; data_reads <= 0; cb_reads <= 0; bad_lba <= 0;
    end else begin
      tick <= tick + 1;
      if (sd_init_req) begin
        init_dly     <= init_dly + 1;
        sd_init_done <= (init_dly == 2);
      end else begin
        sd_init_done <= 1'b0;
      end
      if (sd_rd_valid && sd_rd_ready) begin
        sd_str   <= 1'b1;
        sd_cnt   <= 0;
        sd_lba_q <= sd_rd_lba;
        if (sd_rd_lba == 32'd1) cb_reads <= cb_reads + 1;
        if (sd_rd_lba >= 32'(SRC)) data_reads <= data_reads + 1;
        if ((sd_rd_lba != 32'd1) && (sd_rd_lba >= 32'(SRC + exp_nblk) ||
            sd_rd_lba < 32'(SRC))) bad_lba <= bad_lba + 1;
      end else if (sd_dat_valid && sd_dat_ready) begin
        sd_cnt <= sd_cnt + 1;
        if (sd_cnt == BLK - 1) sd_str <= 1'b0;
      end
    end
  end

  // ---------------- flash front-end model ----------------
  logic [7:0] fmem [SLOT];
  int fmode, fbusy, faddr, fcnt, n_er, n_pg, er_seq, pg_seq, over_err;

  assign fl_ready      = (fmode == 0) && (fbusy == 0);
  assign fl_cmd_ready  = fl_ready && tick[1];
  assign fl_wdat_ready = (fmode == 1) && ((tick % 4) != 1);
  assign fl_rdat_valid = (fmode == 2) && ((tick % 5) != 2);
  assign fl_rdat       = fmem[(faddr + fcnt) % SLOT] ^
                         (((faddr + fcnt) == vf_addr) ? vf_xor : 8'h00);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmode <= 0; fbusy <= 0; faddr <= 0; fcnt <= 0; n_er <= 0; n_pg <= 0;
      er_seq <= 0; pg_seq <= 0; over_err <= 0;
      for (int i = 0; i < SLOT; i++) fmem[i] <= 8'h3C;
    end else begin
      if (fbusy > 0) fbusy <= fbusy - 1;
      if (fl_cmd_valid && fl_cmd_ready) begin
        case (fl_cmd_op)
          2'd0: begin
            if (int'(fl_cmd_addr) != n_er * SEC) er_seq <= er_seq + 1;
            n_er <= n_er + 1;
            for (int i = 0; i < SEC; i++) fmem[(int'(fl_cmd_addr) + i) % SLOT] <= 8'hFF;
            fbusy <= 5;
          end
          2'd1: begin
            if (int'(fl_cmd_addr) != n_pg * PG) pg_seq <= pg_seq + 1;
            n_pg <= n_pg + 1; fmode <= 1; faddr <= int'(fl_cmd_addr); fcnt <= 0;
          end
          default: begin
            fmode <= 2; faddr <= int'(fl_cmd_addr); fcnt <= 0;
          end
        endcase
      end else if (fl_wdat_valid && fl_wdat_ready) begin
        if (fmem[(faddr + fcnt) % SLOT] != 8'hFF) over_err <= over_err + 1;
        fmem[(faddr + fcnt) % SLOT] <= fmem[(faddr + fcnt) % SLOT] & fl_wdat;
        fcnt <= fcnt + 1;
        if (fcnt == PG - 1) begin fmode <= 0; fbusy <= 4; end
      end else if (fl_rdat_valid && fl_rdat_ready) begin
        fcnt <= fcnt + 1;
        if (fcnt == BLK - 1) fmode <= 0;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic start_run(input logic iok, input logic arm, input logic bad,
                           input int len, input int nblk);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_init_ok = iok; cfg_armed = arm; cfg_bad = bad; cfg_len = 32'(len);
    exp_nblk = nblk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input string req, output bit seen);
    seen = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (done_pulse) begin seen = 1'b1; break; end
    end
    chk(seen, req, "finish reached", 0, 1);
  endtask

  function automatic logic [7:0] exp_flash(input int i, input int nblk);
    int secs;
    secs = (nblk * BLK + SEC - 1) / SEC;
    if (i < nblk * BLK) return src_byte(i);
    if (i < secs * SEC) return 8'hFF;
    return 8'h3C;
  endfunction

  // init_ok, armed, bad_csum, length, expected status
  localparam int NV = 9;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 32'd40,  3'd1},
    {1'b1, 1'b0, 1'b0, 32'd40,  3'd1},
    {1'b1, 1'b1, 1'b1, 32'd40,  3'd3},
    {1'b1, 1'b1, 1'b0, 32'd0,   3'd3},
    {1'b1, 1'b1, 1'b0, 32'd129, 3'd3},
    {1'b1, 1'b1, 1'b0, 32'd40,  3'd5},
    {1'b1, 1'b1, 1'b0, 32'd128, 3'd5},
    {1'b1, 1'b1, 1'b0, 32'd16,  3'd5},
    {1'b1, 1'b1, 1'b0, 32'd1,   3'd5}
  };

  initial begin
    #(5.0 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit seen;
    int bad_bytes, nblk, secs, e_st, len, snap_pg, snap_er;
    string st_req;
    cfg_init_ok = 1'b1; cfg_armed = 1'b1; cfg_bad = 1'b0; cfg_len = 32'd40;
    exp_nblk = 0; vf_addr = -1; vf_xor = 8'h00;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(status == 3'd0 && !shell_go && !done_pulse, "R1", "idle status in reset",
        int'(status), 0);
    chk(sd_init_req && !sd_rd_valid && !fl_cmd_valid, "R1", "only init request",
        int'({sd_init_req, sd_rd_valid, fl_cmd_valid}), 4);

    for (int v = 0; v < NV; v++) begin
      len  = int'(VEC[v][34:3]);
      e_st = int'(VEC[v][2:0]);
      nblk = (e_st == 5) ? (len + BLK - 1) / BLK : 0;
      secs = (nblk * BLK + SEC - 1) / SEC;
      start_run(VEC[v][37], VEC[v][36], VEC[v][35], len, nblk);
      st_req = (e_st == 5) ? "R8" : (e_st == 3) ? "R4" : (v == 0) ? "R2" : "R3";
      wait_done(st_req, seen);
      chk(int'(status) == e_st, st_req, "final status", int'(status), e_st);
      chk(cb_reads == (VEC[v][37] ? 1 : 0), "R3", "control block reads",
          cb_reads, VEC[v][37] ? 1 : 0);
      chk(n_er == secs && er_seq == 0, "R5", "erase count/order", n_er, secs);
      chk(n_pg == nblk * (BLK / PG) && pg_seq == 0, "R6", "program count/order",
          n_pg, nblk * (BLK / PG));
      chk(data_reads == 2 * nblk && bad_lba == 0, "R7", "source block reads",
          data_reads, 2 * nblk);
      chk(over_err == 0, "R5", "program only erased bytes", over_err, 0);
      bad_bytes = 0;
      for (int i = 0; i < SLOT; i++)
        if (fmem[i] != exp_flash(i, nblk)) bad_bytes++;
      chk(bad_bytes == 0, "R13", "flash image (R12 handshakes)", bad_bytes, 0);
      @(negedge clk);
      chk(!done_pulse && shell_go && int'(status) == e_st, "R11",
          "pulse one cycle, status held", int'(done_pulse), 0);
    end

    // R9: corrupted read-back byte
    vf_addr = 20; vf_xor = 8'h04;
    start_run(1'b1, 1'b1, 1'b0, 40, 3);
    wait_done("R9", seen);
    chk(status == 3'd4, "R9", "verify fail status", int'(status), 4);
    chk(n_pg == 6, "R9", "programming completed before verify", n_pg, 6);
    vf_addr = -1; vf_xor = 8'h00;

    // R10: abort in the middle of the copy
    start_run(1'b1, 1'b1, 1'b0, 128, 8);
    for (int c = 0; c < 20000 && n_pg < 3; c++) @(negedge clk);
    uart_rx_seen = 1'b1;
    @(negedge clk);
    uart_rx_seen = 1'b0;
    chk(status == 3'd2 && done_pulse, "R10", "abort during copy", int'(status), 2);
    snap_pg = n_pg; snap_er = n_er;
    repeat (60) @(negedge clk);
    chk(n_pg == snap_pg && n_er == snap_er && shell_go, "R10",
        "no flash command after abort", n_pg, snap_pg);

    // R10: abort while waiting for card initialisation
    start_run(1'b1, 1'b1, 1'b0, 40, 0);
    uart_rx_seen = 1'b1;
    @(negedge clk);
    uart_rx_seen = 1'b0;
    chk(status == 3'd2, "R10", "abort during init", int'(status), 2);
    repeat (30) @(negedge clk);
    chk(cb_reads == 0 && n_er == 0, "R10", "no SD read after abort", cb_reads, 0);
    chk(!done_pulse && status == 3'd2, "R11", "status held after abort",
        int'(status), 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule